// File: doc/BRIEF.md
# Synchronized Timer Counter Group

This block holds a set of 16-bit up-counters that a simple register bus can write one byte lane or a whole word at a time. A group register chooses which counters are tied together. A counter in the group shares every write with the rest of the group, and the group starts and stops as one. Every counter steps on a shared single-cycle tick while its run bit is set. It wraps from 0xFFFF to 0x0000 and gives a one-cycle overflow pulse when it wraps.

A byte write to a grouped counter is first combined with the other byte of the counter at the written address. The whole 16-bit result then goes to every counter in the group. A two-bit operating-mode field sits beside the counters. Its changes are refused while either of the two PWM counters is running, and a direct switch between the two PWM modes is also refused. A refused change sets a sticky error flag.

Top module: `sctr_group`

## Requirements
- R1: After reset every counter is 0x0000. The group mask, the run bits, the mode field, the error flag and the overflow pulses are all 0.
- R2: A counter whose run bit is 1 adds one on each cycle with `tick_i` high. A counter whose run bit is 0, or any counter in a cycle without a tick, holds its value.
- R3: A running counter at 0xFFFF wraps to 0x0000 on a tick. Its `ovf_o` bit is high for exactly the one cycle in which the counter first shows 0x0000.
- R4: Addresses 0..NCH-1 select the counters. `wr_be_i[1]` writes bits 15:8 and `wr_be_i[0]` writes bits 7:0. For a counter outside the group, a write changes only the addressed counter, and a lane without a strobe keeps its old byte.
- R5: A word write (`wr_be_i`=2'b11) to a counter inside the group loads that word into every counter in the group.
- R6: A single-lane write to a counter inside the group builds a value from the new byte and the other byte of the addressed counter. That value is loaded into every counter in the group.
- R7: When a bus write to a counter and a tick arrive in the same cycle, the written value is kept and the counter does not step in that cycle.
- R8: A write to address NCH with `wr_be_i[0]` set loads the group mask from `wr_data_i[NCH-1:0]`. A write to address NCH+1 with `wr_be_i[0]` set loads the run bits. A counter outside the group takes its own data bit. Every counter in the group takes the OR of the data bits of all group members.
- R9: The mode field is at address NCH+2, bits 1:0, and is written with `wr_be_i[0]`. A mode write made while counter PWM_A or counter PWM_B is running is refused.
- R10: The mode field is coded as 0x for normal, 10 for reset-synchronized PWM and 11 for complementary PWM. A write that changes 10 directly to 11, or 11 directly to 10, is refused. Every other change is accepted.
- R11: A refused mode write leaves the field unchanged and sets `mode_err_o`. Writing 1 to bit 8 at address NCH+2 with `wr_be_i[1]` clears the flag. If a refusal and a clear fall in the same write, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | AW | Register address |
| wr_be_i | input | 2 | Byte-lane strobes (bit 1 = upper byte) |
| wr_data_i | input | 16 | Write data |
| tick_i | input | 1 | Single-cycle count enable shared by all counters |
| cnt_o | output | NCH*16 | Counter values, counter i at bits 16*i+15:16*i |
| ovf_o | output | NCH | Wrap pulse per counter |
| sync_o | output | NCH | Group mask |
| run_o | output | NCH | Run bits |
| mode_o | output | 2 | Mode field |
| mode_err_o | output | 1 | Sticky refused-mode-write flag |

## Verification
The bench builds the block with its default values: four counters, with counters 2 and 3 as the PWM pair. This small size lets the bench sweep every one of the 16 group masks, against every written counter and every non-empty byte-strobe pattern, with all four counters checked after each write. All sixteen pairs of old and new mode values are also tried with the counters halted. Directed runs cover wrap, a write and a tick in the same cycle, group start and stop, and the error flag's set-wins rule.

// File: rtl/sctr_pkg.sv
package sctr_pkg;
  localparam int LANE_W      = 8;
  localparam int CNT_W       = 16;
  localparam int NLANE       = CNT_W / LANE_W;
  localparam int MODE_W      = 2;
  localparam int ERR_CLR_BIT = 8;

  // replace the strobed byte lanes of old_v with those of new_v
  function automatic logic [CNT_W-1:0] lane_merge(input logic [CNT_W-1:0] old_v,
                                                  input logic [CNT_W-1:0] new_v,
                                                  input logic [NLANE-1:0] be);
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NLANE; b++)
      if (be[b]) r[b*LANE_W +: LANE_W] = new_v[b*LANE_W +: LANE_W];
    return r;
  endfunction

  // both PWM codes have bit 1 set; hopping between them directly is illegal
  function automatic logic mode_step_ok(input logic [MODE_W-1:0] cur,
                                        input logic [MODE_W-1:0] nxt);
    return !(cur[1] && nxt[1] && (cur[0] != nxt[0]));
  endfunction
endpackage

// File: rtl/sctr_channel.sv
module sctr_channel
  import sctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             wrap_o
);
  logic step;
  assign step   = run_i && tick_i && !ld_i;
  assign wrap_o = step && (cnt_o == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= wrap_o;
      if (ld_i)      cnt_o <= ld_val_i;
      else if (step) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/sctr_mode_guard.sv
module sctr_mode_guard
  import sctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              try_i,
  input  logic              clr_i,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] req_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              err_o,
  output logic              acc_o,
  output logic              rej_o
);
  assign acc_o = try_i && !busy_i && mode_step_ok(mode_o, req_i);
  assign rej_o = try_i && !acc_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= '0;
      err_o  <= 1'b0;
    end else begin
      if (acc_o) mode_o <= req_i;
      if (rej_o)      err_o <= 1'b1;
      else if (clr_i) err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sctr_wr_route.sv
module sctr_wr_route
  import sctr_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic                 sel_i,
  input  logic [CH_W-1:0]      idx_i,
  input  logic [NLANE-1:0]     be_i,
  input  logic [CNT_W-1:0]     data_i,
  input  logic [NCH-1:0]       sync_i,
  input  logic [NCH*CNT_W-1:0] cnt_i,
  output logic [NCH-1:0]       ld_o,
  output logic [CNT_W-1:0]     val_o,
  output logic                 bcast_o
);
  logic [CNT_W-1:0] base;
  assign base    = cnt_i[idx_i*CNT_W +: CNT_W];
  assign val_o   = lane_merge(base, data_i, be_i);
  assign bcast_o = sel_i && sync_i[idx_i];

  for (genvar i = 0; i < NCH; i++) begin : g_ld
    assign ld_o[i] = sel_i && ((idx_i == CH_W'(i)) || (bcast_o && sync_i[i]));
  end
endmodule

// File: rtl/sctr_group.sv
module sctr_group
  import sctr_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int PWM_A = 2,
  parameter int PWM_B = 3,
  parameter int AW    = $clog2(NCH + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [NLANE-1:0]     wr_be_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic                 tick_i,
  output logic [NCH*CNT_W-1:0] cnt_o,
  output logic [NCH-1:0]       ovf_o,
  output logic [NCH-1:0]       sync_o,
  output logic [NCH-1:0]       run_o,
  output logic [MODE_W-1:0]    mode_o,
  output logic                 mode_err_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_SYNC = AW'(NCH);
  localparam logic [AW-1:0] A_RUN  = AW'(NCH + 1);
  localparam logic [AW-1:0] A_MODE = AW'(NCH + 2);

  // grouped channels all follow the OR of their requested bits
  function automatic logic [NCH-1:0] run_fold(input logic [NCH-1:0] req,
                                              input logic [NCH-1:0] grp);
    logic any;
    logic [NCH-1:0] r;
    any = |(req & grp);
    for (int i = 0; i < NCH; i++) r[i] = grp[i] ? any : req[i];
    return r;
  endfunction

  // named events for the checker
  logic cnt_wr, sync_wr, run_wr, mode_try, mode_clr, pwm_busy;
  logic mode_acc, mode_rej, bcast;
  logic [NCH-1:0]   ld, wrap;
  logic [CNT_W-1:0] ld_val;

  assign cnt_wr   = wr_en_i && (wr_addr_i < AW'(NCH)) && (|wr_be_i);
  assign sync_wr  = wr_en_i && (wr_addr_i == A_SYNC) && wr_be_i[0];
  assign run_wr   = wr_en_i && (wr_addr_i == A_RUN)  && wr_be_i[0];
  assign mode_try = wr_en_i && (wr_addr_i == A_MODE) && wr_be_i[0];
  assign mode_clr = wr_en_i && (wr_addr_i == A_MODE) && wr_be_i[1]
                    && wr_data_i[ERR_CLR_BIT];
  assign pwm_busy = run_o[PWM_A] || run_o[PWM_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_o <= '0;
      run_o  <= '0;
    end else begin
      if (sync_wr) sync_o <= wr_data_i[NCH-1:0];
      if (run_wr)  run_o  <= run_fold(wr_data_i[NCH-1:0], sync_o);
    end
  end

  sctr_wr_route #(.NCH(NCH), .CH_W(CH_W)) route_i (
    .sel_i   (cnt_wr),
    .idx_i   (wr_addr_i[CH_W-1:0]),
    .be_i    (wr_be_i),
    .data_i  (wr_data_i),
    .sync_i  (sync_o),
    .cnt_i   (cnt_o),
    .ld_o    (ld),
    .val_o   (ld_val),
    .bcast_o (bcast)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sctr_channel ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_o[i]),
      .tick_i   (tick_i),
      .ld_i     (ld[i]),
      .ld_val_i (ld_val),
      .cnt_o    (cnt_o[i*CNT_W +: CNT_W]),
      .ovf_o    (ovf_o[i]),
      .wrap_o   (wrap[i])
    );
  end

  sctr_mode_guard guard_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .try_i  (mode_try),
    .clr_i  (mode_clr),
    .busy_i (pwm_busy),
    .req_i  (wr_data_i[MODE_W-1:0]),
    .mode_o (mode_o),
    .err_o  (mode_err_o),
    .acc_o  (mode_acc),
    .rej_o  (mode_rej)
  );
endmodule

// File: rtl/sctr_group_chk.sv
module sctr_group_chk
  import sctr_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en_i,
  input logic [AW-1:0]        wr_addr_i,
  input logic [NLANE-1:0]     wr_be_i,
  input logic [CNT_W-1:0]     wr_data_i,
  input logic                 tick_i,
  input logic [NCH*CNT_W-1:0] cnt_o,
  input logic [NCH-1:0]       ovf_o,
  input logic [NCH-1:0]       sync_o,
  input logic [MODE_W-1:0]    mode_o,
  input logic                 mode_err_o,
  input logic                 mode_try,
  input logic                 mode_rej,
  input logic                 pwm_busy
);
  logic tgt_grouped;
  assign tgt_grouped = (wr_addr_i < AW'(NCH)) && (|(sync_o & (NCH'(1) << wr_addr_i)));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    logic [CNT_W-1:0] c;
    assign c = cnt_o[i*CNT_W +: CNT_W];

    // R5
    sync_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_be_i == 2'b11 && tgt_grouped && sync_o[i]) |=> (c == $past(wr_data_i)));

    // R7
    own_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_be_i == 2'b11 && wr_addr_i == AW'(i)) |=> (c == $past(wr_data_i)));

    // R3
    ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[i] |-> (c == '0));
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !tick_i) |=> $stable(cnt_o));

  // R9
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_try && pwm_busy) |=> ($stable(mode_o) && mode_err_o));

  // R10
  no_pwm_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[1] && $past(mode_o[1])) |-> (mode_o[0] == $past(mode_o[0])));

  // R11
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rej |=> (mode_err_o && $stable(mode_o)));
endmodule

bind sctr_group sctr_group_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_be_i    (wr_be_i),
  .wr_data_i  (wr_data_i),
  .tick_i     (tick_i),
  .cnt_o      (cnt_o),
  .ovf_o      (ovf_o),
  .sync_o     (sync_o),
  .mode_o     (mode_o),
  .mode_err_o (mode_err_o),
  .mode_try   (mode_try),
  .mode_rej   (mode_rej),
  .pwm_busy   (pwm_busy)
);

// File: tb/sctr_group_tb.sv
module sctr_group_tb_top;
  localparam int N = 4;
  localparam logic [2:0] A_SYNC = 3'd4, A_RUN = 3'd5, A_MODE = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [63:0] cnt;
  logic [3:0]  ovf, sync_m, run_m;
  logic [1:0]  mode;
  logic        merr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [15:0] exp_c [N];

  always #2 clk = ~clk;

  sctr_group dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .tick_i(tick),
    .cnt_o(cnt), .ovf_o(ovf), .sync_o(sync_m), .run_o(run_m),
    .mode_o(mode), .mode_err_o(merr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  function automatic logic [15:0] cval(input int i);
    return cnt[i*16 +: 16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < N; i++) chk("R1 cnt", cval(i), 0);
    chk("R1 flags", {ovf, sync_m, run_m, mode, merr}, 0);

    // R4/R5/R6 sweep: every group mask, target and strobe pattern
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < N; k++)
        for (int be = 1; be < 4; be++) begin
          logic [15:0] d, v;
          string tag;
          wr(A_SYNC, 2'b01, 16'h0, 1'b0);
          for (int i = 0; i < N; i++) begin
            exp_c[i] = 16'(16'h1111 * (i + 1)) ^ 16'(m << 4) ^ 16'(k << 8);
            wr(3'(i), 2'b11, exp_c[i], 1'b0);
          end
          wr(A_SYNC, 2'b01, 16'(m), 1'b0);
          d = 16'hA5C3 ^ 16'(m * 16'h0101) ^ 16'(k << 12) ^ 16'(be);
          v = (((be & 2) != 0) ? (d & 16'hFF00) : (exp_c[k] & 16'hFF00))
            | (((be & 1) != 0) ? (d & 16'h00FF) : (exp_c[k] & 16'h00FF));
          wr(3'(k), 2'(be), d, 1'b0);
          for (int i = 0; i < N; i++)
            if (i == k || (m[k] && m[i])) exp_c[i] = v;
          tag = !m[k] ? "R4 lane write" : (be == 3 ? "R5 group word" : "R6 group byte");
          for (int i = 0; i < N; i++) chk(tag, cval(i), exp_c[i]);
        end

    // R2 counting with independent runs
    wr(A_SYNC, 2'b01, 16'h0, 1'b0);
    for (int i = 0; i < N; i++) wr(3'(i), 2'b11, 16'h0, 1'b0);
    wr(A_RUN, 2'b01, 16'h5, 1'b0);
    ticks(7);
    for (int i = 0; i < N; i++) chk("R2 count", cval(i), (i % 2 == 0) ? 7 : 0);
    wr(A_RUN, 2'b01, 16'h0, 1'b0);
    ticks(3);
    chk("R2 halted", cval(0), 7);
    repeat (4) @(negedge clk);
    chk("R2 no tick", cval(2), 7);

    // R8 group start/stop
    wr(A_SYNC, 2'b01, 16'h3, 1'b0);
    wr(A_RUN, 2'b01, 16'h1, 1'b0);
    chk("R8 group start", run_m, 4'h3);
    ticks(2);
    chk("R8 follower counts", cval(1), 2);
    wr(A_RUN, 2'b01, 16'h6, 1'b0);
    chk("R8 mixed", run_m, 4'h7);
    wr(A_RUN, 2'b01, 16'h4, 1'b0);
    chk("R8 group stop", run_m, 4'h4);
    wr(A_RUN, 2'b01, 16'h0, 1'b0);

    // R3 wrap and overflow pulse
    wr(A_SYNC, 2'b01, 16'h0, 1'b0);
    wr(3'd1, 2'b11, 16'hFFFF, 1'b0);
    wr(A_RUN, 2'b01, 16'h2, 1'b0);
    chk("R3 no pulse before wrap", ovf, 0);
    ticks(1);
    chk("R3 wrapped", cval(1), 0);
    chk("R3 pulse", ovf, 4'h2);
    @(negedge clk);
    chk("R3 pulse ends", ovf, 0);

    // R7 write wins over tick
    wr(A_RUN, 2'b01, 16'h1, 1'b0);
    wr(3'd0, 2'b11, 16'h1234, 1'b1);
    chk("R7 write wins", cval(0), 16'h1234);
    ticks(1);
    chk("R7 next tick", cval(0), 16'h1235);
    wr(A_RUN, 2'b01, 16'h0, 1'b0);

    // R9 mode write while a PWM counter runs
    wr(A_RUN, 2'b01, 16'h4, 1'b0);
    wr(A_MODE, 2'b01, 16'h2, 1'b0);
    chk("R9 busy A mode", mode, 0);
    chk("R9 busy A err", merr, 1);
    wr(A_MODE, 2'b10, 16'h0100, 1'b0);
    chk("R11 clear", merr, 0);
    wr(A_RUN, 2'b01, 16'h8, 1'b0);
    wr(A_MODE, 2'b01, 16'h3, 1'b0);
    chk("R9 busy B mode", mode, 0);
    wr(A_RUN, 2'b01, 16'h1, 1'b0);
    wr(A_MODE, 2'b11, 16'h0102, 1'b0);
    chk("R9 idle pair accepts", mode, 2);
    chk("R11 clear with accept", merr, 0);
    wr(A_RUN, 2'b01, 16'h0, 1'b0);

    // R11 set wins, clear needs bit 8 on upper lane
    wr(A_MODE, 2'b11, 16'h0103, 1'b0);
    chk("R11 set wins", merr, 1);
    chk("R10 hop refused", mode, 2);
    wr(A_MODE, 2'b10, 16'h0000, 1'b0);
    chk("R11 sticky", merr, 1);
    wr(A_MODE, 2'b01, 16'h0100, 1'b0);
    chk("R11 lower lane no clear", merr, 1);
    wr(A_MODE, 2'b10, 16'h0100, 1'b0);
    chk("R11 cleared", merr, 0);

    // R10 every transition pair with the pair halted
    for (int c = 0; c < 4; c++)
      for (int n = 0; n < 4; n++) begin
        bit ok;
        wr(A_MODE, 2'b01, 16'h0, 1'b0);
        wr(A_MODE, 2'b01, 16'(c), 1'b0);
        wr(A_MODE, 2'b10, 16'h0100, 1'b0);
        wr(A_MODE, 2'b01, 16'(n), 1'b0);
        ok = !((c >= 2) && (n >= 2) && (c != n));
        chk("R10 mode", mode, ok ? n : c);
        chk("R11 err", merr, ok ? 0 : 1);
      end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule